// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Controller

This block sequences writes into a byte-wide electrically erasable memory model. Three active-low control pins arrive asynchronously: chip select, output enable and write strobe. The block samples them on its own clock and rejects pulses that are too short. Each accepted strobe places one byte into a page buffer. The byte's offset within the page is taken when the strobe starts, and its data when the strobe ends. After the last strobe, a page-window timer runs out and the block launches a self-timed write. That write first erases each loaded byte to all ones and then programs it. Bytes of the page that were not loaded keep their contents.

The page buffer holds a power of two bytes. A write always targets a single page, and that page is the one the most recent strobe addressed. A host polls completion by reading. While the write runs, any read returns the bitwise inverse of the last byte loaded. After the write, reads return array contents again.

The strobe, address and data pins are plain level pins. They have no valid/ready handshake and no back-pressure: a strobe that arrives while the block is busy is lost. The read port has one register stage. The array depth is set by the address-width parameter, and the full-size part uses 13 bits. The write duration must be at least twice the page size in cycles. A power-good input stands in for the supply monitor.

Top module: `eeprom_page_writer`

## Requirements
- R1: A strobe is accepted only while chip select and the write strobe are both low, output enable is high, power is good and the block is not busy. With output enable low or chip select high, nothing is loaded.
- R2: After the two-stage input synchronizer, a strobe low phase shorter than MIN_PW clock cycles is ignored and loads nothing.
- R3: The low PAGE_W address bits select the buffer slot and are taken at the start of an accepted strobe. The data byte is taken at its end.
- R4: The page, address bits ADDR_W-1 down to PAGE_W, is the value presented with the most recent accepted strobe of the load sequence.
- R5: Any number of bytes from 1 to 2^PAGE_W may be loaded per page, in any slot order. Only loaded locations change.
- R6: Each strobe release restarts the page-window timer, and a low strobe level holds it cleared. A strobe held low never launches a write. No write launches earlier than WINDOW_CYC cycles after a release.
- R7: When the window expires with at least one byte loaded, busy rises and stays high for exactly WRITE_CYC cycles. A single strobe performs a one-byte write through the same path.
- R8: Each loaded location ends holding the loaded value whatever it held before. The erase phase writes all ones, and the program phase then writes the data.
- R9: A read returns its data one cycle after the read address. While busy, it returns the inverse of the last byte loaded. Otherwise it returns the array contents at rd_addr.
- R10: Strobes that occur while busy are ignored and do not start a new write.
- R11: While pwr_good is low, strobes are ignored.
- R12: After reset, busy is low and every array location reads all ones (0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | High when the supply is above the write-inhibit level |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous; low blocks writes |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | ADDR_W | Write address: page in the upper bits, slot in the low PAGE_W bits |
| din | input | DATA_W | Write data byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data, inverted last byte while busy |
| busy | output | 1 | Self-timed write in progress |

## Verification
Two events can fall in the same cycle. The window timer may reach its end at the moment a new strobe goes low, and the end of the self-timed write may coincide with strobe activity. The bench provokes the first by holding the strobe low for several window lengths and then checking that no launch occurred. It then checks that a launch follows only a full window after the release. It provokes the second by strobing a different page while busy, and judges it by reading both pages afterwards and confirming that no second write starts.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef struct packed {
    logic active;  // qualified strobe level this cycle
    logic open;    // strobe met minimum width: capture slot and page
    logic close;   // qualified strobe released: capture data
  } strobe_ev_t;
endpackage

// File: rtl/eepw_strobe_filt.sv
module eepw_strobe_filt import eepw_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int MIN_PW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pwr_good,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              busy,
  output strobe_ev_t        ev,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q
);
  localparam int PW = $clog2(MIN_PW + 1);
  localparam logic [PW-1:0] PW_HIT = PW'(MIN_PW - 1);

  logic [3:0] ctl_s1, ctl_s2;   // {ce_n, oe_n, we_n, pwr_good}
  logic [ADDR_W-1:0] addr_s1;
  logic [DATA_W-1:0] din_s1;
  logic [PW-1:0] pw_cnt;
  logic armed;
  logic active;

  // control, address and data travel through the same two stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1 <= 4'b1110;
      ctl_s2 <= 4'b1110;
      addr_s1 <= '0;
      addr_q <= '0;
      din_s1 <= '0;
      din_q <= '0;
    end else begin
      ctl_s1 <= {ce_n, oe_n, we_n, pwr_good};
      ctl_s2 <= ctl_s1;
      addr_s1 <= addr;
      addr_q <= addr_s1;
      din_s1 <= din;
      din_q <= din_s1;
    end
  end

  assign active = !ctl_s2[3] && ctl_s2[2] && !ctl_s2[1] && ctl_s2[0] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_cnt <= '0;
      armed <= 1'b0;
    end else if (!active) begin
      pw_cnt <= '0;
      armed <= 1'b0;
    end else begin
      if (pw_cnt != PW'(MIN_PW)) pw_cnt <= pw_cnt + 1'b1;
      if (pw_cnt == PW_HIT) armed <= 1'b1;
    end
  end

  assign ev.active = active;
  assign ev.open   = active && (pw_cnt == PW_HIT);
  assign ev.close  = armed && !active && !busy;
endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf import eepw_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_ev_t               ev,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        din_q,
  input  logic                     clr,
  input  logic [PAGE_W-1:0]        rd_slot,
  output logic [(1<<PAGE_W)-1:0]   mask,
  output logic [ADDR_W-PAGE_W-1:0] page,
  output logic [DATA_W-1:0]        slot_data,
  output logic [DATA_W-1:0]        last_byte
);
  localparam int PAGE_N = 1 << PAGE_W;

  logic [DATA_W-1:0] slots [PAGE_N];
  logic [PAGE_W-1:0] cur_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      page <= '0;
      cur_slot <= '0;
      last_byte <= '0;
    end else begin
      if (ev.open) begin
        cur_slot <= addr_q[PAGE_W-1:0];
        page <= addr_q[ADDR_W-1:PAGE_W];
      end
      if (clr) begin
        mask <= '0;
      end else if (ev.close) begin
        mask[cur_slot] <= 1'b1;
        last_byte <= din_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ev.close) slots[cur_slot] <= din_q;
  end

  assign slot_data = slots[rd_slot];
endmodule

// File: rtl/eepw_seq.sv
module eepw_seq #(
  parameter int PAGE_W     = 5,
  parameter int WINDOW_CYC = 40,
  parameter int WRITE_CYC  = 100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<PAGE_W)-1:0] mask,
  input  logic                   strobe_active,
  output logic                   busy,
  output logic                   done,
  output logic                   wr_en,
  output logic                   wr_prog,
  output logic [PAGE_W-1:0]      idx
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int WW = $clog2(WINDOW_CYC + 1);
  localparam int CW = $clog2(WRITE_CYC + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYC - 1);
  localparam logic [CW-1:0] WR_LAST  = CW'(WRITE_CYC - 1);

  logic [WW-1:0] win_cnt;
  logic [CW-1:0] wr_cnt;
  logic pending, launch, in_erase, in_prog;

  assign pending = |mask;
  assign launch  = !busy && pending && !strobe_active && (win_cnt == WIN_LAST);
  assign done    = busy && (wr_cnt == WR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (busy || !pending || strobe_active || launch) begin
      win_cnt <= '0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wr_cnt <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      wr_cnt <= '0;
    end else if (done) begin
      busy <= 1'b0;
      wr_cnt <= '0;
    end else if (busy) begin
      wr_cnt <= wr_cnt + 1'b1;
    end
  end

  // slot walk: first pass erases, second pass programs
  assign in_erase = wr_cnt < CW'(PAGE_N);
  assign in_prog  = !in_erase && (wr_cnt < CW'(2 * PAGE_N));
  assign idx      = wr_cnt[PAGE_W-1:0];
  assign wr_prog  = in_prog;
  assign wr_en    = busy && (in_erase || in_prog) && mask[idx];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer import eepw_pkg::*; #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 5,
  parameter int MIN_PW     = 3,
  parameter int WINDOW_CYC = 40,
  parameter int WRITE_CYC  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;

  strobe_ev_t ev;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic [PAGE_N-1:0] mask_w;
  logic [PG_W-1:0] page_w;
  logic [DATA_W-1:0] slot_data, last_byte_w;
  logic done_w, wr_en_w, wr_prog_w;
  logic [PAGE_W-1:0] idx_w;

  eepw_strobe_filt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PW(MIN_PW)) filt_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_good(pwr_good), .addr(addr), .din(din), .busy(busy),
    .ev(ev), .addr_q(addr_q), .din_q(din_q)
  );

  eepw_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .ev(ev), .addr_q(addr_q), .din_q(din_q),
    .clr(done_w), .rd_slot(idx_w), .mask(mask_w), .page(page_w),
    .slot_data(slot_data), .last_byte(last_byte_w)
  );

  eepw_seq #(.PAGE_W(PAGE_W), .WINDOW_CYC(WINDOW_CYC), .WRITE_CYC(WRITE_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .mask(mask_w), .strobe_active(ev.active),
    .busy(busy), .done(done_w), .wr_en(wr_en_w), .wr_prog(wr_prog_w), .idx(idx_w)
  );

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en_w) begin
      cells[{page_w, idx_w}] <= wr_prog_w ? slot_data : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '1;
    else rd_data <= busy ? ~last_byte_w : cells[rd_addr];
  end
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 5,
  parameter int WRITE_CYC = 100
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic [DATA_W-1:0]      rd_data,
  input logic [DATA_W-1:0]      last_byte,
  input logic [(1<<PAGE_W)-1:0] mask,
  input logic                   wr_en,
  input logic [PAGE_W-1:0]      idx
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else busy_len <= busy ? busy_len + 1 : '0;
  end

  p_busy_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WRITE_CYC);

  p_launch_loaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(|mask));

  p_poll_invert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> rd_data == ~$past(last_byte));

  p_mask_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask));

  p_only_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mask[idx]);
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .DATA_W(DATA_W), .PAGE_W(PAGE_W), .WRITE_CYC(WRITE_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_data(rd_data),
  .last_byte(last_byte_w), .mask(mask_w), .wr_en(wr_en_w), .idx(idx_w)
);

// File: tb/eeprom_page_writer_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb_top;
  localparam int ADDR_W = 11;
  localparam int PAGE_W = 5;
  localparam int MIN_PW = 3;
  localparam int WINDOW_CYC = 40;
  localparam int WRITE_CYC = 100;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int PAGES = DEPTH / PAGE_N;

  logic clk = 0;
  logic rst_n = 0;
  logic pwr_good = 1;
  logic ce_n = 0, oe_n = 1, we_n = 1;
  logic [ADDR_W-1:0] addr = '0, rd_addr = '0;
  logic [7:0] din = '0;
  logic [7:0] rd_data;
  logic busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(ADDR_W), .DATA_W(8), .PAGE_W(PAGE_W), .MIN_PW(MIN_PW),
    .WINDOW_CYC(WINDOW_CYC), .WRITE_CYC(WRITE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int a, input int d, input int low_len);
    @(negedge clk);
    addr = ADDR_W'(a);
    din = 8'(d);
    we_n = 0;
    repeat (low_len) @(negedge clk);
    we_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_done(input logic [7:0] exp_last, output bit seen, output int len);
    seen = 0;
    len = 0;
    for (int i = 0; i < WINDOW_CYC + 60 && !seen; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    if (seen) begin
      len = 1;
      for (int i = 0; i < WRITE_CYC + 20; i++) begin
        @(negedge clk);
        if (!busy) break;
        len++;
        chk(rd_data == ~exp_last, "R9 poll", rd_data, ~exp_last);
      end
    end
  endtask

  task automatic no_busy(input int cycles, input string req);
    bit hit;
    hit = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy) hit = 1;
    end
    chk(!hit, req, hit, 0);
  endtask

  task automatic verify(input int a, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == model[a], req, v, model[a]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    int len, slot, a;
    logic [7:0] v, d;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(busy == 0, "R12 busy", busy, 0);
    rd(0, v); chk(v == 8'hFF, "R12 array", v, 8'hFF);
    rd(DEPTH - 1, v); chk(v == 8'hFF, "R12 array", v, 8'hFF);

    // R3 R5 R7 R8: full-page sweep, alternating slot order
    for (int p = 0; p < PAGES; p++) begin
      for (int k = 0; k < PAGE_N; k++) begin
        slot = (p % 2 == 1) ? PAGE_N - 1 - k : k;
        a = p * PAGE_N + slot;
        d = 8'((p * 37 + slot * 11 + 5) & 8'hFF);
        strobe(a, d, 6);
        model[a] = d;
      end
      if (p == 0) no_busy(WINDOW_CYC - 10, "R6 window not elapsed");
      wait_done(d, seen, len);
      chk(seen, "R7 launch", seen, 1);
      chk(len == WRITE_CYC, "R7 busy length", len, WRITE_CYC);
    end
    for (int i = 0; i < DEPTH; i++) verify(i, "R5 sweep contents");

    // R5 R8: partial overwrite of a full page, arbitrary order
    strobe(5 * PAGE_N + 7, 8'h3C, 6);  model[5 * PAGE_N + 7] = 8'h3C;
    strobe(5 * PAGE_N + 0, 8'hC3, 6);  model[5 * PAGE_N + 0] = 8'hC3;
    strobe(5 * PAGE_N + 30, 8'h00, 6); model[5 * PAGE_N + 30] = 8'h00;
    wait_done(8'h00, seen, len);
    chk(seen && len == WRITE_CYC, "R8 partial write", len, WRITE_CYC);
    for (int s = 0; s < PAGE_N; s++) verify(5 * PAGE_N + s, "R5 partial page");

    // R7 single byte write
    strobe(12 * PAGE_N + 9, 8'h81, 6); model[12 * PAGE_N + 9] = 8'h81;
    wait_done(8'h81, seen, len);
    chk(seen, "R7 byte write", seen, 1);
    for (int s = 8; s < 11; s++) verify(12 * PAGE_N + s, "R8 byte write");

    // R4 page from last strobe
    strobe(10 * PAGE_N + 2, 8'h5A, 6);
    strobe(11 * PAGE_N + 3, 8'hA5, 6);
    model[11 * PAGE_N + 2] = 8'h5A;
    model[11 * PAGE_N + 3] = 8'hA5;
    wait_done(8'hA5, seen, len);
    verify(11 * PAGE_N + 2, "R4 first byte in last page");
    verify(11 * PAGE_N + 3, "R4 last byte");
    verify(10 * PAGE_N + 2, "R4 earlier page untouched");

    // R2 short pulse ignored
    strobe(20 * PAGE_N + 4, 8'h11, 1);
    no_busy(WINDOW_CYC + 30, "R2 short pulse no write");
    verify(20 * PAGE_N + 4, "R2 short pulse contents");

    // R1 output enable low blocks, chip select high blocks
    oe_n = 0;
    strobe(21 * PAGE_N + 4, 8'h22, 6);
    oe_n = 1;
    no_busy(WINDOW_CYC + 30, "R1 oe low no write");
    verify(21 * PAGE_N + 4, "R1 oe low contents");
    ce_n = 1;
    strobe(21 * PAGE_N + 5, 8'h23, 6);
    ce_n = 0;
    no_busy(WINDOW_CYC + 30, "R1 ce high no write");
    verify(21 * PAGE_N + 5, "R1 ce high contents");

    // R11 power lockout
    pwr_good = 0;
    strobe(22 * PAGE_N + 6, 8'h44, 6);
    pwr_good = 1;
    no_busy(WINDOW_CYC + 30, "R11 power low no write");
    verify(22 * PAGE_N + 6, "R11 power low contents");

    // R10 strobe during busy ignored
    strobe(30 * PAGE_N + 1, 8'h6D, 6); model[30 * PAGE_N + 1] = 8'h6D;
    for (int i = 0; i < WINDOW_CYC + 60 && !busy; i++) @(negedge clk);
    chk(busy == 1, "R10 busy reached", busy, 1);
    strobe(31 * PAGE_N + 1, 8'h77, 6);
    for (int i = 0; i < WRITE_CYC + 20 && busy; i++) @(negedge clk);
    no_busy(WINDOW_CYC + 30, "R10 no second write");
    verify(30 * PAGE_N + 1, "R10 first write");
    verify(31 * PAGE_N + 1, "R10 ignored strobe");

    // R6 strobe held low stalls, release restarts window
    @(negedge clk);
    addr = ADDR_W'(40 * PAGE_N + 17);
    din = 8'h9E;
    we_n = 0;
    no_busy(3 * WINDOW_CYC, "R6 held low no launch");
    we_n = 1;
    model[40 * PAGE_N + 17] = 8'h9E;
    no_busy(WINDOW_CYC - 4, "R6 release window");
    wait_done(8'h9E, seen, len);
    chk(seen, "R6 launch after release", seen, 1);
    verify(40 * PAGE_N + 17, "R6 held strobe contents");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule